// File: doc/BRIEF.md
# Banded Matrix-Vector Systolic Array

This block computes y = A·x for a square matrix A whose nonzero entries sit in a band of P+Q-1 diagonals. Below the main diagonal there are P-1 diagonals and above it there are Q-1. The array is a line of P+Q-1 multiply-accumulate elements, one for each diagonal. Vector entries enter at element 0 and travel towards the far end. Running partial sums start at zero at the far end and travel back towards element 0, so the two streams move in opposite directions. Each element holds one register stage on each path. At every element it passes, a partial sum adds the product of the coefficient present there and the vector entry present there.

The user offers one vector entry every second cycle and drives each element's coefficient lane on a fixed skew. Finished results leave at element 0, each marked by a one-cycle strobe. Matrices can follow each other without a pause or after any idle gap. The hardware grows with the band width P+Q-1. It does not grow with the matrix size.

Top module: `banded_mv_array`

## Requirements
- R1: During reset and after reset is released, until the first result strobe, y_valid is 0 and y_data is 0.
- R2: For every row i of the matrix, the result equals the sum of A[i][j]*x[j] over all j with -(P-1) <= j-i <= Q-1. Element k receives the coefficients of the diagonal j-i = Q-1-k on bits [k*DW+DW-1 : k*DW] of a_data.
- R3: Skew rule. Let x_j be accepted at clock edge t-k, and let x_i, the entry for the same index as row i, be accepted at clock edge t+k+2-2Q. Then the value element k must see on its lane at clock edge t is A[i][j]. Any slot that falls outside the matrix is fed as zero.
- R4: Suppose x_i is accepted at clock edge E. Then after clock edge E+2Q-2, for one cycle, y_valid is 1 and y_data holds y_i. This is 2Q-1 cycles after the cycle that presented x_i.
- R5: The values on x_data and on a coefficient lane have no effect on any result in cycles where that element holds no accepted vector entry.
- R6: A new vector may follow the last entry of the previous one two cycles later, with no gap. This works because the zeroed band-edge coefficients keep the two matrices apart.
- R7: The idle time between two matrices may be any number of cycles, and the results stay exact.
- R8: x_valid is never high in two consecutive cycles (usage rule). Given that rule, y_valid is never high in two consecutive cycles, and two neighbouring elements never both hold a valid entry.
- R9: Exactly one strobe is produced for each accepted entry, and no strobe is produced without a matching accepted entry.
- R10: Arithmetic is two's complement. Products of DW-bit operands accumulate exactly into YW bits, including the case where every operand equals -2^(DW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_valid | input | 1 | An entry of the vector is presented this cycle |
| x_data | input | DW | Signed vector entry |
| a_data | input | (P+Q-1)*DW | Signed coefficient lanes, lane k for element k |
| y_valid | output | 1 | A finished result is on y_data |
| y_data | output | YW | Signed result of one row |

## Verification
Each result is due 2Q-1 cycles after the cycle that carried its vector entry. When the driver offers an entry, it records that due cycle next to the expected sum. The monitor samples on the falling edge and compares both the value and the cycle in which the strobe appears. A strobe that arrives early or late, or an entry that never produces one, is reported as a timing failure under R4 or as a count failure under R9. The coefficient lanes are filled from the skew rule using the edges on which entries were actually accepted. Because of this, gaps between matrices and back-to-back runs shift the schedule exactly as they shift the hardware.

// File: rtl/bmv_pkg.sv
`timescale 1ns/1ps
package bmv_pkg;
    // number of multiply-accumulate elements for a band of p below, q above
    function automatic int band_elems(input int p, input int q);
        return p + q - 1;
    endfunction

    // cycles from an accepted entry to its result strobe
    function automatic int strobe_delay(input int q);
        return 2 * q - 1;
    endfunction
endpackage

// File: rtl/bmv_pe.sv
`timescale 1ns/1ps
module bmv_pe #(
    parameter int DW = 8,
    parameter int YW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xv_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [YW-1:0] y_i,
    output logic                 xv_o,
    output logic signed [DW-1:0] x_o,
    output logic signed [YW-1:0] y_o
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic                 xv;
        logic signed [DW-1:0] x;
        logic signed [YW-1:0] y;
    } pe_state_t;

    pe_state_t            st_d, st_q;
    logic signed [PW-1:0] prod;

    always_comb begin
        prod    = PW'(x_i) * PW'(a_i);
        st_d.xv = xv_i;
        st_d.x  = x_i;
        // an empty slot on the entry path leaves the passing sum untouched
        st_d.y  = xv_i ? (y_i + YW'(prod)) : y_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xv_o = st_q.xv;
    assign x_o  = st_q.x;
    assign y_o  = st_q.y;
endmodule

// File: rtl/bmv_strobe_delay.sv
`timescale 1ns/1ps
module bmv_strobe_delay #(
    parameter int DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);
    logic [DEPTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d    = sr_q << 1;
        sr_d[0] = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign out_valid = sr_q[DEPTH-1];
endmodule

// File: rtl/banded_mv_array.sv
`timescale 1ns/1ps
module banded_mv_array
    import bmv_pkg::*;
#(
    parameter int P  = 2,
    parameter int Q  = 3,
    parameter int DW = 8,
    parameter int YW = 2 * DW + 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            x_valid,
    input  logic signed [DW-1:0]            x_data,
    input  logic [band_elems(P,Q)*DW-1:0]   a_data,
    output logic                            y_valid,
    output logic signed [YW-1:0]            y_data
);
    localparam int W   = band_elems(P, Q);
    localparam int LAT = strobe_delay(Q);

    logic [W-1:0]          xv_s;
    logic [W-1:0][DW-1:0]  x_s;
    logic [W-1:0][YW-1:0]  y_s;

    for (genvar k = 0; k < W; k++) begin : g_pe
        logic                 xv_in;
        logic signed [DW-1:0] x_in;
        logic signed [YW-1:0] y_in;

        // entries flow upward in k
        if (k == 0) begin : g_head
            assign xv_in = x_valid;
            assign x_in  = x_data;
        end else begin : g_xlink
            assign xv_in = xv_s[k-1];
            assign x_in  = x_s[k-1];
        end

        // partial sums flow downward in k, starting from zero
        if (k == W - 1) begin : g_tail
            assign y_in = '0;
        end else begin : g_ylink
            assign y_in = y_s[k+1];
        end

        bmv_pe #(.DW(DW), .YW(YW)) u_pe (
            .clk  (clk),
            .rst_n(rst_n),
            .xv_i (xv_in),
            .x_i  (x_in),
            .a_i  (a_data[k*DW +: DW]),
            .y_i  (y_in),
            .xv_o (xv_s[k]),
            .x_o  (x_s[k]),
            .y_o  (y_s[k])
        );
    end

    bmv_strobe_delay #(.DEPTH(LAT)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (x_valid),
        .out_valid(y_valid)
    );

    assign y_data = y_s[0];
endmodule

// File: rtl/bmv_checker.sv
`timescale 1ns/1ps
module bmv_checker #(
    parameter int P = 2,
    parameter int Q = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             x_valid,
    input logic             y_valid,
    input logic [P+Q-2:0]   xv_s
);
    localparam int W = P + Q - 1;

    logic [15:0] inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else if (x_valid && !y_valid) inflight_q <= inflight_q + 16'd1;
        else if (!x_valid && y_valid) inflight_q <= inflight_q - 16'd1;
    end

    // R8: usage rule on the entry stream
    a_r8_x_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        x_valid |=> !x_valid);

    // R8: results never arrive in adjacent cycles
    a_r8_y_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid);

    // R9: every strobe has an accepted entry behind it
    a_r9_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (inflight_q != 16'd0));

    // R9: no more entries in flight than the latency window can hold
    a_r9_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= 16'(Q));

    for (genvar k = 0; k + 1 < W; k++) begin : g_pair
        // R8: neighbouring elements never both hold a valid entry
        a_r8_pe_interleave: assert property (@(posedge clk) disable iff (!rst_n)
            !(xv_s[k] && xv_s[k+1]));
    end
endmodule

bind banded_mv_array bmv_checker #(.P(P), .Q(Q)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .x_valid(x_valid),
    .y_valid(y_valid),
    .xv_s   (xv_s)
);

// File: tb/banded_mv_array_tb.sv
`timescale 1ns/1ps
module banded_mv_lane #(
    parameter int P = 2,
    parameter int Q = 3
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_bad,
    output logic done
);
    localparam int DW = 8;
    localparam int YW = 2 * DW + 4;
    localparam int W  = P + Q - 1;
    localparam int NR = 16;
    localparam int ME = 200;

    logic                  x_valid;
    logic signed [DW-1:0]  x_data;
    logic [W*DW-1:0]       a_data;
    logic                  y_valid;
    logic signed [YW-1:0]  y_data;

    banded_mv_array #(.P(P), .Q(Q), .DW(DW), .YW(YW)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_valid(x_valid),
        .x_data (x_data),
        .a_data (a_data),
        .y_valid(y_valid),
        .y_data (y_data)
    );

    typedef struct { longint val; int due; int row; } exp_t;
    exp_t sb[$];

    int rl[4] = '{5, 1, 7, 3};
    int band [NR][W];
    int xval [NR];
    int run_of [NR];
    int loc [NR];
    int entry [NR];
    int slot [ME];
    longint yexp [NR];
    int edges = 0;
    int chk_d = 0, bad_d = 0, chk_m = 0, bad_m = 0;
    logic drv_done = 1'b0;
    logic prev_yv = 1'b0;

    assign n_chk = chk_d + chk_m;
    assign n_bad = bad_d + bad_m;
    assign done  = drv_done;

    always @(posedge clk) edges <= edges + 1;

    function automatic int rnd8();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    initial begin
        int g, e, last_rel, base, ig, jg, ex, er, d, coef, rel;
        x_valid = 1'b0;
        x_data  = '0;
        a_data  = '0;
        for (int s = 0; s < ME; s++) slot[s] = -1;
        g = 0;
        e = 4;
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < rl[r]; l++) begin
                if (r == 2 && l == 0) e += 6;   // R7: idle gap before the third matrix
                run_of[g] = r;
                loc[g]    = l;
                entry[g]  = e;
                slot[e]   = g;
                e += 2;
                g++;
            end
        end
        last_rel = e;
        // band rows, zero outside each matrix; last matrix uses extreme values (R10)
        for (int i = 0; i < NR; i++) begin
            xval[i] = (run_of[i] == 3) ? -128 : rnd8();
            for (int dd = 0; dd < W; dd++) begin
                int col;
                col = loc[i] + dd - (P - 1);
                if (col < 0 || col >= rl[run_of[i]]) band[i][dd] = 0;
                else band[i][dd] = (run_of[i] == 3) ? -128 : rnd8();
            end
        end
        for (int i = 0; i < NR; i++) begin
            yexp[i] = 0;
            for (int dd = 0; dd < W; dd++)
                if (band[i][dd] != 0)
                    yexp[i] += longint'(band[i][dd]) * longint'(xval[i + dd - (P - 1)]);
        end

        wait (rst_n === 1'b1);
        @(negedge clk);
        // R1: reset state
        chk_d++;
        if (y_valid !== 1'b0 || y_data !== '0) begin
            bad_d++;
            $display("FAIL R1 P=%0d Q=%0d reset outputs: y_valid=%0b y_data=%0d expected 0/0",
                     P, Q, y_valid, y_data);
        end
        base = edges;
        rel  = 0;
        while (rel <= last_rel + 2 * Q + 6) begin
            rel = edges + 1 - base;
            if (rel < ME && slot[rel] >= 0) begin
                exp_t it;
                x_valid = 1'b1;
                x_data  = DW'(xval[slot[rel]]);
                it.val  = yexp[slot[rel]];
                it.due  = edges + 1 + 2 * Q - 2;
                it.row  = slot[rel];
                sb.push_back(it);
            end else begin
                x_valid = 1'b0;
                x_data  = DW'($urandom);   // R5: junk on idle slots
            end
            for (int k = 0; k < W; k++) begin
                ex = rel - k;
                er = rel + k + 2 - 2 * Q;
                if (ex >= 0 && ex < ME && slot[ex] >= 0) begin
                    jg = slot[ex];
                    coef = 0;
                    if (er >= 0 && er < ME && slot[er] >= 0) begin
                        ig = slot[er];
                        d  = jg - ig + P - 1;
                        if (d >= 0 && d < W) coef = band[ig][d];
                    end
                end else begin
                    coef = int'($urandom);   // R5: lane content with no entry present
                end
                a_data[k*DW +: DW] = coef[DW-1:0];
            end
            @(negedge clk);
        end
        x_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R9: every accepted entry produced its strobe
        chk_d++;
        if (sb.size() != 0) begin
            bad_d++;
            $display("FAIL R9 P=%0d Q=%0d results outstanding: actual %0d expected 0",
                     P, Q, sb.size());
        end
        drv_done = 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n && !drv_done) begin
            if (sb.size() != 0 && sb[0].due < edges) begin
                chk_m++;
                bad_m++;
                $display("FAIL R4 P=%0d Q=%0d row %0d missing: actual none expected strobe at edge %0d",
                         P, Q, sb[0].row, sb[0].due);
                void'(sb.pop_front());
            end
            if (y_valid) begin
                chk_m++;
                if (prev_yv) begin
                    bad_m++;
                    $display("FAIL R8 P=%0d Q=%0d strobes adjacent: actual 1 expected 0", P, Q);
                end
                if (sb.size() == 0) begin
                    chk_m++;
                    bad_m++;
                    $display("FAIL R9 P=%0d Q=%0d strobe without entry: actual y=%0d expected none",
                             P, Q, y_data);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk_m++;
                    if (longint'(y_data) != it.val) begin
                        bad_m++;
                        $display("FAIL R2 R3 R5 R6 R7 R10 P=%0d Q=%0d row %0d: actual %0d expected %0d",
                                 P, Q, it.row, y_data, it.val);
                    end
                    chk_m++;
                    if (edges != it.due) begin
                        bad_m++;
                        $display("FAIL R4 P=%0d Q=%0d row %0d strobe edge: actual %0d expected %0d",
                                 P, Q, it.row, edges, it.due);
                    end
                end
            end
            prev_yv <= y_valid;
        end
    end
endmodule

module banded_mv_array_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   chk [4];
    int   bad [4];
    logic [3:0] dn;

    always #2 clk = ~clk;   // 250 MHz

    banded_mv_lane #(.P(2), .Q(3)) u_l0 (.clk(clk), .rst_n(rst_n), .n_chk(chk[0]), .n_bad(bad[0]), .done(dn[0]));
    banded_mv_lane #(.P(3), .Q(1)) u_l1 (.clk(clk), .rst_n(rst_n), .n_chk(chk[1]), .n_bad(bad[1]), .done(dn[1]));
    banded_mv_lane #(.P(1), .Q(1)) u_l2 (.clk(clk), .rst_n(rst_n), .n_chk(chk[2]), .n_bad(bad[2]), .done(dn[2]));
    banded_mv_lane #(.P(3), .Q(3)) u_l3 (.clk(clk), .rst_n(rst_n), .n_chk(chk[3]), .n_bad(bad[3]), .done(dn[3]));

    initial begin
        int cyc, tot_c, tot_b;
        cyc = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        while (dn !== 4'hF && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        tot_c = 0;
        tot_b = 0;
        for (int i = 0; i < 4; i++) begin
            tot_c += chk[i];
            tot_b += bad[i];
        end
        if (dn !== 4'hF) begin
            tot_c++;
            tot_b++;
            $display("FAIL watchdog: actual lanes done %b expected 1111", dn);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", tot_c, tot_b);
        $finish;
    end
endmodule